// File: doc/BRIEF.md
# Transmit Credit Flow Controller

This block keeps the transmit-side credit ledger for one port of an accelerator link. The port carries four message channels: request, originator data, read response and write response. Each channel owns two credit classes, one for headers and one for 64-byte data beats. Each class holds a shared pool counter that any of the four virtual channels may draw on, plus one dedicated counter per virtual channel. The receiver feeds credits back through a return bundle. Every return names a channel, a class, a pool or dedicated flag, a virtual channel and a count of 1 to 15.

Each channel raises a send request tagged with a virtual channel and a beat count. A request is eligible only when one header credit and all of its data credits can be covered in the current cycle. A round-robin arbiter then grants at most one eligible channel, combinationally. The granted request's credits are debited at the next clock edge. The dedicated counter is spent before the pool. A return that would lift any counter above the configured buffer depth is discarded and reported.

Top module: `cfc_top`

## Requirements
- R1: After reset every counter is zero, so no request is granted and `overflow_o` is low until credits are returned.
- R2: A credit return takes effect on the clock edge that samples it: a request that depends on it is not granted in the cycle the return is presented, and it is granted in the following cycle.
- R3: A dedicated credit (`ret_pool_i`=0) serves only the virtual channel given by `ret_vc_i`. A pool credit (`ret_pool_i`=1) serves any virtual channel.
- R4: When a header can be paid either from the dedicated counter of its virtual channel or from the pool, the dedicated counter is charged and the pool is left intact.
- R5: A grant needs one header credit plus `beats` data credits of the requesting channel available together. Otherwise the request is not granted and no counter changes.
- R6: Data credits for a multi-beat request are drawn from the dedicated counter up to its value, and the remainder comes from the pool.
- R7: A return and a debit hitting the same counter in one cycle net to old value minus debit plus return.
- R8: A return that would raise a counter above MAX_DEPTH (32 by default) is dropped, leaving that counter at its value minus any same-cycle debit. `overflow_o` is then high for exactly the next cycle. A return that reaches exactly MAX_DEPTH is accepted without an error.
- R9: At most one channel is granted per cycle. The arbiter serves eligible channels in rotating order, starting after the last one granted. Channel 0 comes first after reset.
- R10: Credits are private to their channel and class. Channel encoding is 0 request, 1 originator data, 2 read response, 3 write response. `ret_data_i`=0 selects the header class and 1 selects the data class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_valid_i | input | 1 | Credit return present this cycle |
| ret_chan_i | input | 2 | Channel receiving the credits |
| ret_data_i | input | 1 | 0 header class, 1 data class |
| ret_pool_i | input | 1 | 1 pool credit, 0 dedicated credit |
| ret_vc_i | input | 2 | Virtual channel for a dedicated return |
| ret_cnt_i | input | 4 | Number of credits returned |
| req_valid_i | input | 4 | Send request, one bit per channel |
| req_vc_i | input | 8 | Virtual channel per channel, 2 bits each, channel 0 lowest |
| req_beats_i | input | 12 | Data beats per channel, 3 bits each, channel 0 lowest |
| gnt_o | output | 4 | One-hot send grant, combinational |
| overflow_o | output | 1 | One-cycle pulse after a dropped return |

## Verification
On every cycle, the assertions check four things. Grants are one-hot and backed by a request. A debit never exceeds the credits available. No counter rises above the buffer depth. A counter changes only when a debit or a return touches it. Other behaviour can only be shown by the bench's scenarios, because it depends on earlier returns reaching the ports as grants: the one-cycle return latency, the binding of dedicated credits to their virtual channel, the dedicated-before-pool order, the all-or-nothing grant, same-cycle netting, the exact overflow threshold and the rotation order.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [1:0] {
    CH_REQ   = 2'd0,
    CH_ODATA = 2'd1,
    CH_RDRSP = 2'd2,
    CH_WRRSP = 2'd3
  } chan_e;

  typedef enum logic {
    CLS_HDR  = 1'b0,
    CLS_DATA = 1'b1
  } cls_e;

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfc_credit_class.sv
module cfc_credit_class #(
  parameter int NUM_VC    = 4,
  parameter int MAX_DEPTH = 32,
  parameter int RET_W     = 4,
  parameter int AMT_W     = 3
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                ret_valid_i,
  input  logic                                ret_pool_i,
  input  logic [cfc_pkg::idx_width(NUM_VC)-1:0] ret_vc_i,
  input  logic [RET_W-1:0]                    ret_cnt_i,
  input  logic [cfc_pkg::idx_width(NUM_VC)-1:0] qry_vc_i,
  input  logic [AMT_W-1:0]                    qry_amt_i,
  input  logic                                debit_i,
  output logic                                avail_o,
  output logic                                ovf_o
);
  localparam int VC_W  = cfc_pkg::idx_width(NUM_VC);
  localparam int CNT_W = $clog2(MAX_DEPTH + 1);
  localparam int SUM_W = ((CNT_W > RET_W) ? CNT_W : RET_W) + ((AMT_W > 1) ? AMT_W : 1) + 2;
  localparam int NCNT  = NUM_VC + 1;  // index NUM_VC is the pool

  logic [NCNT-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [NCNT-1:0][SUM_W-1:0] take_w, add_w, net_w;
  logic [NCNT-1:0]            ovf_w;
  logic [SUM_W-1:0]           ded_sel, pool_cur, amt, ded_take, pool_take;
  logic                       ovf_q;

  always_comb begin
    ded_sel   = SUM_W'(cnt_q[qry_vc_i]);
    pool_cur  = SUM_W'(cnt_q[NUM_VC]);
    amt       = SUM_W'(qry_amt_i);
    ded_take  = (amt <= ded_sel) ? amt : ded_sel;
    pool_take = amt - ded_take;
  end

  assign avail_o = (ded_sel + pool_cur) >= amt;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    if (i == NUM_VC) begin : g_pool
      assign take_w[i] = debit_i ? pool_take : '0;
      assign add_w[i]  = (ret_valid_i && ret_pool_i) ? SUM_W'(ret_cnt_i) : '0;
    end else begin : g_ded
      assign take_w[i] = (debit_i && qry_vc_i == VC_W'(i)) ? ded_take : '0;
      assign add_w[i]  = (ret_valid_i && !ret_pool_i && ret_vc_i == VC_W'(i))
                         ? SUM_W'(ret_cnt_i) : '0;
    end
    assign net_w[i] = SUM_W'(cnt_q[i]) - take_w[i] + add_w[i];
    assign ovf_w[i] = net_w[i] > SUM_W'(MAX_DEPTH);
    assign cnt_d[i] = ovf_w[i] ? CNT_W'(SUM_W'(cnt_q[i]) - take_w[i]) : CNT_W'(net_w[i]);

    a_r8_counter_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      SUM_W'(cnt_q[i]) <= SUM_W'(MAX_DEPTH));
    a_r7_counter_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_w[i] == '0 && add_w[i] == '0) |=> $stable(cnt_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= |ovf_w;
    end
  end

  assign ovf_o = ovf_q;

  a_r5_debit_covered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debit_i |-> avail_o);
endmodule

// File: rtl/cfc_rr_arb.sv
module cfc_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = cfc_pkg::idx_width(N);

  logic [IW-1:0] last_q, win;
  logic          any;
  int            idx;

  always_comb begin
    gnt_o = '0;
    any   = 1'b0;
    win   = last_q;
    idx   = 0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last_q) + off) % N;
      if (!any && req_i[idx]) begin
        any        = 1'b1;
        win        = IW'(idx);
        gnt_o[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= IW'(N - 1);
    else if (any) last_q <= win;
  end

  a_r9_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r9_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/cfc_top.sv
module cfc_top #(
  parameter int NUM_CH    = 4,
  parameter int NUM_VC    = 4,
  parameter int MAX_DEPTH = 32,
  parameter int RET_W     = 4,
  parameter int BEAT_W    = 3
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        ret_valid_i,
  input  logic [cfc_pkg::idx_width(NUM_CH)-1:0]       ret_chan_i,
  input  logic                                        ret_data_i,
  input  logic                                        ret_pool_i,
  input  logic [cfc_pkg::idx_width(NUM_VC)-1:0]       ret_vc_i,
  input  logic [RET_W-1:0]                            ret_cnt_i,
  input  logic [NUM_CH-1:0]                           req_valid_i,
  input  logic [NUM_CH*cfc_pkg::idx_width(NUM_VC)-1:0] req_vc_i,
  input  logic [NUM_CH*BEAT_W-1:0]                    req_beats_i,
  output logic [NUM_CH-1:0]                           gnt_o,
  output logic                                        overflow_o
);
  import cfc_pkg::*;

  localparam int CH_W = idx_width(NUM_CH);
  localparam int VC_W = idx_width(NUM_VC);

  logic [NUM_CH-1:0] hdr_avail, dat_avail, hdr_ovf, dat_ovf, eligible;
  logic              ret_hdr, ret_dat;

  assign ret_hdr = ret_valid_i && (cls_e'(ret_data_i) == CLS_HDR);
  assign ret_dat = ret_valid_i && (cls_e'(ret_data_i) == CLS_DATA);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = ret_chan_i == CH_W'(c);

    cfc_credit_class #(
      .NUM_VC(NUM_VC), .MAX_DEPTH(MAX_DEPTH), .RET_W(RET_W), .AMT_W(BEAT_W)
    ) i_hdr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ret_valid_i(ret_hdr && hit),
      .ret_pool_i (ret_pool_i),
      .ret_vc_i   (ret_vc_i),
      .ret_cnt_i  (ret_cnt_i),
      .qry_vc_i   (req_vc_i[c*VC_W +: VC_W]),
      .qry_amt_i  (BEAT_W'(1)),
      .debit_i    (gnt_o[c]),
      .avail_o    (hdr_avail[c]),
      .ovf_o      (hdr_ovf[c])
    );

    cfc_credit_class #(
      .NUM_VC(NUM_VC), .MAX_DEPTH(MAX_DEPTH), .RET_W(RET_W), .AMT_W(BEAT_W)
    ) i_dat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ret_valid_i(ret_dat && hit),
      .ret_pool_i (ret_pool_i),
      .ret_vc_i   (ret_vc_i),
      .ret_cnt_i  (ret_cnt_i),
      .qry_vc_i   (req_vc_i[c*VC_W +: VC_W]),
      .qry_amt_i  (req_beats_i[c*BEAT_W +: BEAT_W]),
      .debit_i    (gnt_o[c]),
      .avail_o    (dat_avail[c]),
      .ovf_o      (dat_ovf[c])
    );

    assign eligible[c] = req_valid_i[c] && hdr_avail[c] && dat_avail[c];

    a_r5_grant_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[c] |-> (hdr_avail[c] && dat_avail[c]));
  end

  cfc_rr_arb #(.N(NUM_CH)) i_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (eligible),
    .gnt_o (gnt_o)
  );

  assign overflow_o = |{hdr_ovf, dat_ovf};
endmodule

// File: tb/test_cfc_top.sv
module test_cfc_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ret_valid_i = 1'b0;
  logic [1:0]  ret_chan_i = '0;
  logic        ret_data_i = 1'b0;
  logic        ret_pool_i = 1'b0;
  logic [1:0]  ret_vc_i = '0;
  logic [3:0]  ret_cnt_i = '0;
  logic [3:0]  req_valid_i = '0;
  logic [7:0]  req_vc_i = '0;
  logic [11:0] req_beats_i = '0;
  logic [3:0]  gnt_o;
  logic        overflow_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cfc_top i_cfc_top (
    .clk_i(clk), .rst_ni(rst_ni), .ret_valid_i(ret_valid_i), .ret_chan_i(ret_chan_i),
    .ret_data_i(ret_data_i), .ret_pool_i(ret_pool_i), .ret_vc_i(ret_vc_i),
    .ret_cnt_i(ret_cnt_i), .req_valid_i(req_valid_i), .req_vc_i(req_vc_i),
    .req_beats_i(req_beats_i), .gnt_o(gnt_o), .overflow_o(overflow_o)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; ret_valid_i = 1'b0; req_valid_i = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // Return credits for one cycle; the next negedge sees them applied.
  task automatic give(int ch, bit dat, bit pool, int vc, int cnt);
    ret_valid_i = 1'b1; ret_chan_i = 2'(ch); ret_data_i = dat;
    ret_pool_i = pool; ret_vc_i = 2'(vc); ret_cnt_i = 4'(cnt);
    @(negedge clk);
    ret_valid_i = 1'b0;
  endtask

  task automatic set_req(int ch, int vc, int beats);
    req_valid_i[ch] = 1'b1;
    req_vc_i[ch*2 +: 2] = 2'(vc);
    req_beats_i[ch*3 +: 3] = 3'(beats);
  endtask

  task automatic try_send(int ch, int vc, int beats, int exp, string tag);
    set_req(ch, vc, beats);
    #1;
    check(tag, int'(gnt_o), exp ? (1 << ch) : 0);
    @(negedge clk);
    req_valid_i = '0;
  endtask

  task automatic t_reset();
    do_reset();
    req_valid_i = 4'hF;
    #1;
    check("R1 no grant after reset", int'(gnt_o), 0);
    check("R1 overflow low after reset", int'(overflow_o), 0);
    @(negedge clk);
    req_valid_i = '0;
  endtask

  task automatic t_latency();
    do_reset();
    ret_valid_i = 1'b1; ret_chan_i = 2'd0; ret_data_i = 1'b0; ret_pool_i = 1'b1;
    ret_vc_i = 2'd0; ret_cnt_i = 4'd1;
    set_req(0, 0, 0);
    #1;
    check("R2 not granted in return cycle", int'(gnt_o), 0);
    @(negedge clk);
    ret_valid_i = 1'b0;
    #1;
    check("R2 granted next cycle", int'(gnt_o), 1);
    @(negedge clk);
    req_valid_i = '0;
    try_send(0, 0, 0, 0, "R2 single credit spent");
  endtask

  task automatic t_vc_bind();
    do_reset();
    give(1, 0, 0, 2, 1);
    try_send(1, 1, 0, 0, "R3 dedicated credit refused to other vc");
    try_send(1, 2, 0, 1, "R3 dedicated credit used by own vc");
    give(1, 0, 1, 0, 1);
    try_send(1, 3, 0, 1, "R3 pool credit used by any vc");
  endtask

  task automatic t_ded_first();
    do_reset();
    give(2, 0, 0, 0, 1);
    give(2, 0, 1, 0, 1);
    try_send(2, 0, 0, 1, "R4 vc0 header");
    try_send(2, 1, 0, 1, "R4 pool kept for vc1");
    try_send(2, 0, 0, 0, "R4 all spent");
  endtask

  task automatic t_whole();
    do_reset();
    give(1, 0, 1, 0, 1);
    give(1, 1, 1, 0, 2);
    try_send(1, 0, 3, 0, "R5 short on data");
    try_send(1, 0, 2, 1, "R5 full request after refusal");
    try_send(1, 0, 0, 0, "R5 header gone");
    give(1, 1, 1, 0, 4);
    try_send(1, 0, 1, 0, "R5 data without header");
  endtask

  task automatic t_split();
    do_reset();
    give(1, 0, 1, 0, 3);
    give(1, 1, 0, 1, 2);
    give(1, 1, 1, 0, 2);
    try_send(1, 1, 3, 1, "R6 three beats over ded and pool");
    try_send(1, 0, 1, 1, "R6 pool beat left");
    try_send(1, 1, 1, 0, "R6 data exhausted");
    try_send(1, 1, 0, 1, "R6 header only still ok");
  endtask

  task automatic t_net();
    do_reset();
    give(3, 0, 1, 0, 1);
    ret_valid_i = 1'b1; ret_chan_i = 2'd3; ret_data_i = 1'b0; ret_pool_i = 1'b1;
    ret_vc_i = 2'd0; ret_cnt_i = 4'd1;
    set_req(3, 0, 0);
    #1;
    check("R7 grant during return", int'(gnt_o), 8);
    @(negedge clk);
    ret_valid_i = 1'b0; req_valid_i = '0;
    try_send(3, 0, 0, 1, "R7 netted credit present");
    try_send(3, 0, 0, 0, "R7 netted to one");
  endtask

  task automatic t_overflow();
    do_reset();
    give(2, 0, 1, 0, 15);
    give(2, 0, 1, 0, 15);
    give(2, 0, 1, 0, 2);
    check("R8 exact depth accepted", int'(overflow_o), 0);
    give(2, 0, 1, 0, 1);
    check("R8 overflow pulse", int'(overflow_o), 1);
    @(negedge clk);
    check("R8 pulse one cycle", int'(overflow_o), 0);
    for (int k = 0; k < 32; k++) begin
      set_req(2, k % 4, 0);
      #1;
      if (gnt_o != 4'b0100) check("R8 depth credits usable", int'(gnt_o), 4);
      @(negedge clk);
      req_valid_i = '0;
    end
    check("R8 32 credits consumed", 1, 1);
    try_send(2, 0, 0, 0, "R8 dropped return not added");
  endtask

  task automatic t_rr();
    do_reset();
    for (int c = 0; c < 4; c++) give(c, 0, 1, 0, 4);
    for (int c = 0; c < 4; c++) set_req(c, 0, 0);
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R9 rotation all four", int'(gnt_o), 1 << k);
      @(negedge clk);
    end
    req_valid_i = 4'b0101;
    #1; check("R9 wrap to ch0", int'(gnt_o), 1);
    @(negedge clk);
    #1; check("R9 ch2 after ch0", int'(gnt_o), 4);
    @(negedge clk);
    #1; check("R9 back to ch0", int'(gnt_o), 1);
    @(negedge clk);
    req_valid_i = '0;
  endtask

  task automatic t_chan_sep();
    do_reset();
    give(0, 0, 1, 0, 2);
    give(0, 1, 1, 0, 2);
    try_send(3, 0, 0, 0, "R10 other channel credit unusable");
    give(2, 1, 1, 0, 4);
    try_send(2, 0, 0, 0, "R10 data credit is not header credit");
    try_send(0, 0, 2, 1, "R10 owner channel granted");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_vc_bind();
    t_ded_first();
    t_whole();
    t_split();
    t_net();
    t_overflow();
    t_rr();
    t_chan_sep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule